// File: doc/BRIEF.md
# Paged Indirect Register Access Bridge

This block sits on the device side of a 16-bit management register port. It lets a host that can only move 16-bit words reach a 32-bit internal register space. The host addresses the block with a 5-bit device number and a 5-bit register number. Writes carry 16 bits of data on a strobe. A read strobe returns 16 bits one cycle later.

A page-select register picks which bank of registers the host sees. When the bus-access page is selected, a bank of staging registers appears. It holds a mode bit, a write address, write data and a read address, each as a high and a low half. The host fills these registers half by half. Writing the low data half starts a single 32-bit write on the internal bus. Writing the low read-address half starts a single 32-bit read.

The internal bus uses a request/ready handshake. The result of each read is kept in a snapshot register, and the host fetches it in two halves. In increment mode, the staged address advances by one word after each completed access. This lets the host walk a block of registers without restaging the address.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset the page number is 0, `busy_o` and `bus_req_o` are low, and `rd_data_o` is 0.
- R2: Writing register 0x1f stores data bits [2:0] as the page number. Reading 0x1f on any page returns the page number in bits [2:0] and zeros elsewhere. No other access changes the page.
- R3: Reads and writes whose device address differs from `DEV_ADDR` are ignored. Such a read leaves `rd_data_o` unchanged.
- R4: Staging registers 0x10 to 0x18 exist only on page 4. On any other page, writes to them have no effect and start no bus cycle, and reads of them return 0.
- R5: On page 4 the staging halves read back what was written. The halves are: 0x11/0x12 write address high/low, 0x13/0x14 write data high/low, and 0x15/0x16 read address high/low. Register 0x10 reads back only bit 15, which is the increment flag (0 means fixed address).
- R6: Writing 0x14 on page 4 starts one bus write. Its address is {0x11,0x12} and its data is {0x13, the value just written}. Writing 0x11, 0x12 or 0x13 starts nothing.
- R7: Writing 0x16 on page 4 starts one bus read at {0x15, the value just written}. After completion, 0x17 returns bits [31:16] of the returned word and 0x18 returns bits [15:0].
- R8: The read snapshot changes only when a bus read completes. Reading 0x17 and 0x18 at any time between completions gives halves of the same word.
- R9: `busy_o` is high from the cycle after a launch until the cycle after `bus_ready_i` is seen. While the request waits, `bus_addr_o`, `bus_we_o` and `bus_wdata_o` hold steady.
- R10: While busy, all writes to page-4 staging registers are dropped. This includes any attempt to launch a second access.
- R11: With the increment flag set, a completed write adds 4 to the staged write address and a completed read adds 4 to the staged read address. With the flag clear, the addresses stay the same.
- R12: The increment carries from the low address half into the high half. For example, 0x0000FFFC becomes 0x00010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_addr_i | input | 5 | Device address of the host access |
| reg_addr_i | input | 5 | Register number of the host access |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 16 | Host write data |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 16 | Read data, valid the cycle after `rd_en_i` |
| busy_o | output | 1 | Internal bus access in flight |
| bus_req_o | output | 1 | Internal bus request |
| bus_we_o | output | 1 | Internal bus write (1) or read (0) |
| bus_addr_o | output | 32 | Internal bus address |
| bus_wdata_o | output | 32 | Internal bus write data |
| bus_ready_i | input | 1 | Internal bus completion |
| bus_rdata_i | input | 32 | Internal bus read data, valid with ready |

## Verification
The bench targets these corner cases:

- **Launch-register staging on the wrong page.** A bridge that leaked these writes would start stray bus cycles, or would corrupt staged addresses seen later on page 4.
- **Writes that land during a slow bus access.** A design that accepted them would overwrite the staged address or issue a second access.
- **Increment across a 64K address boundary.** A design that increments only the low half would wrap to 0x0000 in the same high half.
- **Snapshot consistency.** Reads of the result halves are interleaved with new address staging. A design that read the bus data directly, or refreshed the snapshot too early, would return mixed halves.

// File: rtl/pib_pkg.sv
package pib_pkg;
  localparam logic [4:0] REG_PAGE  = 5'h1f;
  localparam logic [4:0] REG_MODE  = 5'h10;
  localparam logic [4:0] REG_WA_HI = 5'h11;
  localparam logic [4:0] REG_WA_LO = 5'h12;
  localparam logic [4:0] REG_WD_HI = 5'h13;
  localparam logic [4:0] REG_WD_LO = 5'h14;
  localparam logic [4:0] REG_RA_HI = 5'h15;
  localparam logic [4:0] REG_RA_LO = 5'h16;
  localparam logic [4:0] REG_RD_HI = 5'h17;
  localparam logic [4:0] REG_RD_LO = 5'h18;

  localparam logic [2:0] PAGE_STD  = 3'd0;
  localparam logic [2:0] PAGE_EXT1 = 3'd1;
  localparam logic [2:0] PAGE_BUS  = 3'd4;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_WRITE = 2'd1,
    BUS_READ  = 2'd2
  } bus_state_e;
endpackage

// File: rtl/pib_page_sel.sv
module pib_page_sel #(
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [PW-1:0] page_i,
  output logic [PW-1:0] page_o
);
  logic [PW-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (wr_i) page_q <= page_i;
  end

  assign page_o = page_q;
endmodule

// File: rtl/pib_stage.sv
module pib_stage
  import pib_pkg::*;
#(
  parameter int HW   = 16,
  parameter int STEP = 4,
  localparam int BW  = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [4:0]    reg_i,
  input  logic [HW-1:0] wdata_i,
  input  logic          done_i,
  input  logic          done_we_i,
  input  logic [BW-1:0] done_rdata_i,
  output logic          incr_o,
  output logic [BW-1:0] wa_o,
  output logic [BW-1:0] wd_o,
  output logic [BW-1:0] ra_o,
  output logic [BW-1:0] snap_o,
  output logic          launch_wr_o,
  output logic          launch_rd_o,
  output logic [BW-1:0] launch_waddr_o,
  output logic [BW-1:0] launch_wdata_o,
  output logic [BW-1:0] launch_raddr_o
);
  logic          incr_q;
  logic [BW-1:0] wa_q, wd_q, ra_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      incr_q <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
      ra_q   <= '0;
      snap_q <= '0;
    end else begin
      if (wr_i) begin
        case (reg_i)
          REG_MODE:  incr_q        <= wdata_i[HW-1];
          REG_WA_HI: wa_q[BW-1:HW] <= wdata_i;
          REG_WA_LO: wa_q[HW-1:0]  <= wdata_i;
          REG_WD_HI: wd_q[BW-1:HW] <= wdata_i;
          REG_WD_LO: wd_q[HW-1:0]  <= wdata_i;
          REG_RA_HI: ra_q[BW-1:HW] <= wdata_i;
          REG_RA_LO: ra_q[HW-1:0]  <= wdata_i;
          default: ;
        endcase
      end
      // wr_i is gated by !busy, done only occurs while busy: no overlap
      if (done_i) begin
        if (done_we_i) begin
          if (incr_q) wa_q <= wa_q + BW'(STEP);
        end else begin
          snap_q <= done_rdata_i;
          if (incr_q) ra_q <= ra_q + BW'(STEP);
        end
      end
    end
  end

  assign launch_wr_o    = wr_i && (reg_i == REG_WD_LO);
  assign launch_rd_o    = wr_i && (reg_i == REG_RA_LO);
  assign launch_waddr_o = wa_q;
  assign launch_wdata_o = {wd_q[BW-1:HW], wdata_i};
  assign launch_raddr_o = {ra_q[BW-1:HW], wdata_i};

  assign incr_o = incr_q;
  assign wa_o   = wa_q;
  assign wd_o   = wd_q;
  assign ra_o   = ra_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/pib_bus_mst.sv
module pib_bus_mst
  import pib_pkg::*;
#(
  parameter int BW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_wr_i,
  input  logic          launch_rd_i,
  input  logic [BW-1:0] waddr_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [BW-1:0] raddr_i,
  input  logic          ready_i,
  input  logic [BW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [BW-1:0] addr_o,
  output logic [BW-1:0] wdata_o,
  output logic          done_o,
  output logic          done_we_o,
  output logic [BW-1:0] done_rdata_o
);
  bus_state_e    state_q;
  logic [BW-1:0] addr_q, wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        BUS_IDLE: begin
          if (launch_wr_i) begin
            state_q <= BUS_WRITE;
            addr_q  <= waddr_i;
            wdata_q <= wdata_i;
          end else if (launch_rd_i) begin
            state_q <= BUS_READ;
            addr_q  <= raddr_i;
          end
        end
        BUS_WRITE, BUS_READ: if (ready_i) state_q <= BUS_IDLE;
        default: state_q <= BUS_IDLE;
      endcase
    end
  end

  assign req_o        = (state_q != BUS_IDLE);
  assign we_o         = (state_q == BUS_WRITE);
  assign addr_o       = addr_q;
  assign wdata_o      = wdata_q;
  assign done_o       = req_o && ready_i;
  assign done_we_o    = we_o;
  assign done_rdata_o = rdata_i;
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
  import pib_pkg::*;
#(
  parameter logic [4:0] DEV_ADDR = 5'd1,
  parameter int         HW       = 16,
  parameter int         PW       = 3,
  parameter int         STEP     = 4,
  localparam int        BW       = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    dev_addr_i,
  input  logic [4:0]    reg_addr_i,
  input  logic          wr_en_i,
  input  logic [HW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [HW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [BW-1:0] bus_addr_o,
  output logic [BW-1:0] bus_wdata_o,
  input  logic          bus_ready_i,
  input  logic [BW-1:0] bus_rdata_i
);
  logic          dev_hit, on_bus_page, page_wr, stage_wr;
  logic [PW-1:0] page;
  logic          incr;
  logic [BW-1:0] wa, wd, ra, snap;
  logic          launch_wr, launch_rd;
  logic [BW-1:0] launch_waddr, launch_wdata, launch_raddr;
  logic          done, done_we;
  logic [BW-1:0] done_rdata;
  logic [HW-1:0] rd_mux, rd_q;

  assign dev_hit     = (dev_addr_i == DEV_ADDR);
  assign on_bus_page = (page == PW'(PAGE_BUS));
  assign page_wr     = wr_en_i && dev_hit && (reg_addr_i == REG_PAGE);
  assign stage_wr    = wr_en_i && dev_hit && on_bus_page && !bus_req_o;

  pib_page_sel #(.PW(PW)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (page_wr),
    .page_i (wr_data_i[PW-1:0]),
    .page_o (page)
  );

  pib_stage #(.HW(HW), .STEP(STEP)) u_stage (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (stage_wr),
    .reg_i          (reg_addr_i),
    .wdata_i        (wr_data_i),
    .done_i         (done),
    .done_we_i      (done_we),
    .done_rdata_i   (done_rdata),
    .incr_o         (incr),
    .wa_o           (wa),
    .wd_o           (wd),
    .ra_o           (ra),
    .snap_o         (snap),
    .launch_wr_o    (launch_wr),
    .launch_rd_o    (launch_rd),
    .launch_waddr_o (launch_waddr),
    .launch_wdata_o (launch_wdata),
    .launch_raddr_o (launch_raddr)
  );

  pib_bus_mst #(.BW(BW)) u_mst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_wr_i  (launch_wr),
    .launch_rd_i  (launch_rd),
    .waddr_i      (launch_waddr),
    .wdata_i      (launch_wdata),
    .raddr_i      (launch_raddr),
    .ready_i      (bus_ready_i),
    .rdata_i      (bus_rdata_i),
    .req_o        (bus_req_o),
    .we_o         (bus_we_o),
    .addr_o       (bus_addr_o),
    .wdata_o      (bus_wdata_o),
    .done_o       (done),
    .done_we_o    (done_we),
    .done_rdata_o (done_rdata)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == REG_PAGE) begin
      rd_mux[PW-1:0] = page;
    end else if (on_bus_page) begin
      case (reg_addr_i)
        REG_MODE:  rd_mux[HW-1] = incr;
        REG_WA_HI: rd_mux = wa[BW-1:HW];
        REG_WA_LO: rd_mux = wa[HW-1:0];
        REG_WD_HI: rd_mux = wd[BW-1:HW];
        REG_WD_LO: rd_mux = wd[HW-1:0];
        REG_RA_HI: rd_mux = ra[BW-1:HW];
        REG_RA_LO: rd_mux = ra[HW-1:0];
        REG_RD_HI: rd_mux = snap[BW-1:HW];
        REG_RD_LO: rd_mux = snap[HW-1:0];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (rd_en_i && dev_hit) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;
  assign busy_o    = bus_req_o;
endmodule

// File: rtl/pib_checker.sv
module pib_checker #(
  parameter logic [4:0] DEV_ADDR = 5'd1,
  parameter int         HW       = 16,
  parameter int         PW       = 3,
  parameter int         STEP     = 4,
  localparam int        BW       = 2 * HW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    dev_addr_i,
  input logic [4:0]    reg_addr_i,
  input logic          wr_en_i,
  input logic [HW-1:0] wr_data_i,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [BW-1:0] bus_addr_o,
  input logic [BW-1:0] bus_wdata_o,
  input logic          bus_ready_i,
  input logic [PW-1:0] page,
  input logic          incr,
  input logic [BW-1:0] ra,
  input logic [BW-1:0] snap
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_addr_o) &&
      $stable(bus_we_o) && $stable(bus_wdata_o))); // R9

  AST_LAUNCH_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(wr_en_i && dev_addr_i == DEV_ADDR && page == PW'(4) &&
      (reg_addr_i == 5'h14 || reg_addr_i == 5'h16))); // R4

  AST_WR_LOW_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_req_o) && bus_we_o) |-> bus_wdata_o[HW-1:0] == $past(wr_data_i)); // R6

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_o && bus_ready_i && !bus_we_o) |=> $stable(snap)); // R8

  AST_INCR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ready_i && !bus_we_o && incr) |=> ra == $past(ra) + BW'(STEP)); // R11

  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && dev_addr_i == DEV_ADDR && reg_addr_i == 5'h1f) |=> $stable(page)); // R2
endmodule

bind paged_reg_bridge pib_checker #(
  .DEV_ADDR (DEV_ADDR),
  .HW       (HW),
  .PW       (PW),
  .STEP     (STEP)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_addr_i  (dev_addr_i),
  .reg_addr_i  (reg_addr_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ready_i (bus_ready_i),
  .page        (page),
  .incr        (incr),
  .ra          (ra),
  .snap        (snap)
);

// File: tb/paged_reg_bridge_tb_top.sv
module paged_reg_bridge_tb_top;
  localparam logic [4:0] DEV = 5'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dev_addr = DEV, reg_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        busy, bus_req, bus_we, bus_ready = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int n_wr_ops = 0, n_rd_ops = 0;
  int lat_cfg = 0, wait_left = 0;
  logic [31:0] last_waddr = '0, last_wdata = '0, last_raddr = '0;

  always #5 clk = ~clk;

  paged_reg_bridge #(.DEV_ADDR(DEV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(dev_addr), .reg_addr_i(reg_addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .busy_o(busy), .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ready_i(bus_ready), .bus_rdata_i(bus_rdata)
  );

  function automatic logic [31:0] resp(input logic [31:0] a);
    return {a[15:0] ^ 16'h5a3c, a[31:16] + 16'h0101};
  endfunction

  // bus responder with configurable wait states
  always @(negedge clk) begin
    if (bus_req && !bus_ready) begin
      if (wait_left == 0) begin
        bus_ready = 1'b1;
        if (bus_we) begin
          n_wr_ops++; last_waddr = bus_addr; last_wdata = bus_wdata;
        end else begin
          n_rd_ops++; last_raddr = bus_addr; bus_rdata = resp(bus_addr);
        end
      end else wait_left--;
    end else if (!bus_req) begin
      bus_ready = 1'b0;
      wait_left = lat_cfg;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] r, input logic [15:0] d, input logic [4:0] dv = DEV);
    @(negedge clk);
    dev_addr = dv; reg_addr = r; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; dev_addr = DEV;
  endtask

  task automatic rd(input logic [4:0] r, output logic [15:0] d, input logic [4:0] dv = DEV);
    @(negedge clk);
    dev_addr = dv; reg_addr = r; rd_en = 1'b1;
    @(negedge clk);
    d = rd_data; rd_en = 1'b0; dev_addr = DEV;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, hi, lo;
    int ops;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 req", 32'(bus_req), 0);
    check("R1 rd_data", 32'(rd_data), 0);
    rd(5'h1f, v); check("R1 page", 32'(v), 0);

    // R2 page select, upper bits ignored
    wr(5'h1f, 16'hfffc); rd(5'h1f, v); check("R2 page=4", 32'(v), 32'h4);
    wr(5'h1f, 16'h0001); rd(5'h1f, v); check("R2 page=1", 32'(v), 32'h1);

    // R3 foreign device address
    wr(5'h1f, 16'h0004, 5'd7); rd(5'h1f, v); check("R3 page unchanged", 32'(v), 32'h1);
    rd(5'h1f, v, 5'd9); check("R3 rd_data held", 32'(v), 32'h1);

    // stage known values on page 4
    wr(5'h1f, 16'h0004);
    wr(5'h11, 16'h1111); wr(5'h12, 16'h2222); wr(5'h13, 16'h3333);
    wr(5'h15, 16'h5555);
    check("R6 no launch from 0x11-0x13", 32'(n_wr_ops), 0);
    rd(5'h11, v); check("R5 wa_hi", 32'(v), 32'h1111);
    rd(5'h12, v); check("R5 wa_lo", 32'(v), 32'h2222);
    rd(5'h13, v); check("R5 wd_hi", 32'(v), 32'h3333);
    rd(5'h15, v); check("R5 ra_hi", 32'(v), 32'h5555);

    // R4 page gating on pages 0 and 1
    for (int p = 0; p < 2; p++) begin
      wr(5'h1f, 16'(p));
      wr(5'h11, 16'haaaa); wr(5'h14, 16'h0001); wr(5'h16, 16'h0002);
      @(negedge clk);
      check("R4 no bus op off page", 32'(n_wr_ops + n_rd_ops), 0);
      check("R4 not busy off page", 32'(busy), 0);
      rd(5'h11, v); check("R4 read 0 off page", 32'(v), 0);
    end
    wr(5'h1f, 16'h0004);
    rd(5'h11, v); check("R4 wa_hi untouched", 32'(v), 32'h1111);

    // R6 write launch, R9 busy with wait states
    lat_cfg = 3;
    wr(5'h14, 16'h4444);
    check("R9 busy after launch", 32'(busy), 1);
    check("R9 bus addr", bus_addr, 32'h11112222);
    wait_idle();
    check("R6 one write", 32'(n_wr_ops), 1);
    check("R6 waddr", last_waddr, 32'h11112222);
    check("R6 wdata", last_wdata, 32'h33334444);
    rd(5'h14, v); check("R5 wd_lo", 32'(v), 32'h4444);

    // R7 read launch and R10 drop while busy
    lat_cfg = 5;
    wr(5'h16, 16'h0010);
    wr(5'h11, 16'hdead);
    wr(5'h14, 16'hbeef);
    wait_idle();
    check("R10 no extra write", 32'(n_wr_ops), 1);
    check("R7 one read", 32'(n_rd_ops), 1);
    check("R7 raddr", last_raddr, 32'h55550010);
    rd(5'h11, v); check("R10 wa_hi kept", 32'(v), 32'h1111);
    rd(5'h14, v); check("R10 wd_lo kept", 32'(v), 32'h4444);
    rd(5'h17, hi); rd(5'h18, lo);
    check("R7 rdata", {hi, lo}, resp(32'h55550010));

    // R8 snapshot stable while staging changes
    wr(5'h15, 16'h7777); wr(5'h12, 16'h0000);
    rd(5'h18, lo); rd(5'h17, hi);
    check("R8 snapshot stable", {hi, lo}, resp(32'h55550010));
    check("R11 fixed mode no step", 32'(n_rd_ops), 1);
    rd(5'h16, v); check("R11 fixed ra_lo", 32'(v), 32'h0010);

    // R11/R12 increment mode
    lat_cfg = 1;
    wr(5'h10, 16'hffff); rd(5'h10, v); check("R5 mode readback", 32'(v), 32'h8000);
    wr(5'h11, 16'h0000); wr(5'h12, 16'hfffc); wr(5'h13, 16'h0000);
    wr(5'h14, 16'h0001); wait_idle();
    check("R11 first waddr", last_waddr, 32'h0000fffc);
    rd(5'h11, hi); rd(5'h12, lo);
    check("R12 carry", {hi, lo}, 32'h00010000);
    wr(5'h14, 16'h0002); wait_idle();
    check("R12 second waddr", last_waddr, 32'h00010000);
    wr(5'h15, 16'h2000); wr(5'h16, 16'h0000); wait_idle();
    rd(5'h16, v); check("R11 ra step", 32'(v), 32'h0004);
    wr(5'h10, 16'h0000);

    // constrained random accesses, fixed address mode
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, d;
      a = $urandom() & 32'hfffffffc;
      d = $urandom();
      lat_cfg = $urandom_range(0, 3);
      if ($urandom_range(0, 1) == 1) begin
        ops = n_wr_ops;
        wr(5'h11, a[31:16]); wr(5'h12, a[15:0]); wr(5'h13, d[31:16]); wr(5'h14, d[15:0]);
        wait_idle();
        check("R6 rand count", 32'(n_wr_ops), 32'(ops + 1));
        check("R6 rand addr", last_waddr, a);
        check("R6 rand data", last_wdata, d);
      end else begin
        wr(5'h15, a[31:16]); wr(5'h16, a[15:0]);
        wait_idle();
        rd(5'h17, hi); rd(5'h18, lo);
        check("R7 rand addr", last_raddr, a);
        check("R7 rand data", {hi, lo}, resp(a));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule